// File: doc/BRIEF.md
# UART Data Register Buffering

This block is the processor-facing data register of a UART. It occupies one bus address that is shared by two unrelated storage paths. A bus write to the address fills a single transmit holding buffer. A bus read from the same address returns the oldest character of a two-entry receive FIFO and removes it. The serial side is abstract. A transmit shifter reports through a ready input that it is empty and takes a byte on a one-cycle load strobe. A receiver delivers each finished character on a push strobe.

The character width is selected from 5 to 8 bits by a 2-bit code. Bits above the selected width are removed from written bytes before they reach the shifter. The same bits read as zero on received characters. Three flags report the buffer state to software:
- a transmit-buffer-empty flag, which shows when a write will be taken;
- a receive-available flag;
- a sticky overrun flag for characters lost while the FIFO was full.

Top module: `uart_data_reg_buf`

## Requirements
- R1: A write taken into the transmit buffer is handed to the shifter unchanged apart from width masking. It appears on `shf_data` in the cycle `shf_load` is high.
- R2: A read of the data address returns the oldest character held in the receive FIFO on `bus_rdata`, combinationally in the same cycle as `bus_rd`.
- R3: Width code `char_sz` selects the character width: 0 = 5 bits, 1 = 6 bits, 2 = 7 bits, 3 = 8 bits. Bits of a written byte at and above the selected width are dropped before the byte reaches the shifter.
- R4: Bits of a received character at and above the width selected when it was pushed read back as zero.
- R5: A write made while `tx_empty` is low is discarded. The buffered byte and `tx_empty` are unchanged afterwards.
- R6: `tx_empty` is 1 after reset and clears in the cycle after a taken write. `shf_load` is high exactly when the buffer holds a byte, `tx_en` is high and `shf_ready` is high. `tx_empty` is set again in the cycle after the load. While `tx_en` is low, a buffered byte stays put and `tx_empty` stays low.
- R7: The receive FIFO holds two characters. Every read of the data address that finds it non-empty removes the head entry. If a push and a read occur in the same cycle on a full FIFO, the push is kept.
- R8: `rx_avail` is high exactly when the receive FIFO holds at least one character.
- R9: A push that finds the FIFO full, without a read in the same cycle, is dropped and sets `rx_overrun`. Any read of the data address clears `rx_overrun` in the next cycle.
- R10: A read while the receive FIFO is empty returns zero and leaves the FIFO contents and count unchanged.
- R11: After reset `tx_empty` is 1, `rx_avail` is 0, `rx_overrun` is 0 and `shf_load` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe to the data address |
| bus_rd | input | 1 | Read strobe to the data address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| char_sz | input | 2 | Character width code (0..3 = 5..8 bits) |
| tx_en | input | 1 | Transmitter enable |
| shf_ready | input | 1 | Transmit shifter is empty |
| shf_load | output | 1 | Load strobe to the shifter |
| shf_data | output | 8 | Byte presented to the shifter |
| rx_push | input | 1 | Received character strobe |
| rx_char | input | 8 | Received character |
| tx_empty | output | 1 | Transmit buffer can take a write |
| rx_avail | output | 1 | Receive FIFO is not empty |
| rx_overrun | output | 1 | Sticky flag: a character was dropped |

## Verification
The width-masking property on read data only holds if `char_sz` stays unchanged while characters wait in the FIFO. The stimulus therefore changes the width code only after it has drained the receive FIFO and emptied the transmit buffer. The properties place no rule on the strobes: writes while full, reads while empty, and pushes on a full FIFO with or without a same-cycle read are all legal. The bench drives these cases on purpose, both in directed sequences and in long random runs at each width. The load and empty-flag properties treat `shf_ready` as a free input that may change on any cycle, so the stimulus toggles it at random.

// File: rtl/uart_dr_pkg.sv
`timescale 1ns/1ps
package uart_dr_pkg;

    localparam int DW = 8;

    typedef enum logic [1:0] {
        CSZ_5 = 2'd0,
        CSZ_6 = 2'd1,
        CSZ_7 = 2'd2,
        CSZ_8 = 2'd3
    } csz_e;

    typedef struct packed {
        logic          full;
        logic [DW-1:0] dat;
    } hold_t;

    // Ones in the bit positions that belong to a character of the given width.
    function automatic logic [DW-1:0] csz_mask(input csz_e sz);
        logic [DW-1:0] m;
        m = '0;
        for (int i = 0; i < DW; i++) begin
            if (i < 5 + int'(sz)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/dr_tx_hold.sv
`timescale 1ns/1ps
module dr_tx_hold
    import uart_dr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] mask,
    input  logic          tx_en,
    input  logic          shf_ready,
    output logic          shf_load,
    output logic [DW-1:0] shf_data,
    output logic          empty
);

    hold_t hold_q;
    logic  accept;

    assign accept   = wr & ~hold_q.full;
    assign shf_load = hold_q.full & tx_en & shf_ready;
    assign shf_data = hold_q.dat;
    assign empty    = ~hold_q.full;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (accept) begin
            hold_q.full <= 1'b1;
            hold_q.dat  <= wdata & mask;
        end else if (shf_load) begin
            hold_q.full <= 1'b0;
        end
    end

endmodule

// File: rtl/dr_rx_fifo.sv
`timescale 1ns/1ps
module dr_rx_fifo #(
    parameter int DEPTH = 2,
    parameter int WIDTH = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] pdata,
    input  logic             rd,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    count,
    output logic             ovr
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wp_q, rp_q;
    logic [CW-1:0]    cnt_q;
    logic             pop, full, take, drop;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (cnt_q == CW'(DEPTH));
    assign pop   = rd & (cnt_q != '0);
    assign take  = push & (~full | pop);
    assign drop  = push & ~take;
    assign head  = mem[rp_q];
    assign count = cnt_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[g] <= '0;
            end else if (take && wp_q == PW'(g)) begin
                mem[g] <= pdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
            ovr   <= 1'b0;
        end else begin
            if (take) wp_q <= ptr_inc(wp_q);
            if (pop)  rp_q <= ptr_inc(rp_q);
            case ({take, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
            if (drop)    ovr <= 1'b1;
            else if (rd) ovr <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_data_reg_buf.sv
`timescale 1ns/1ps
module uart_data_reg_buf
    import uart_dr_pkg::*;
#(
    parameter int RX_DEPTH = 2,
    localparam int CW      = $clog2(RX_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    input  logic [1:0]    char_sz,
    input  logic          tx_en,
    input  logic          shf_ready,
    output logic          shf_load,
    output logic [7:0]    shf_data,
    input  logic          rx_push,
    input  logic [7:0]    rx_char,
    output logic          tx_empty,
    output logic          rx_avail,
    output logic          rx_overrun
);

    logic [DW-1:0] width_mask;
    logic [DW-1:0] rx_head;
    logic [CW-1:0] rx_count;

    assign width_mask = csz_mask(csz_e'(char_sz));

    dr_tx_hold u_tx (
        .clk       (clk),
        .rst       (rst),
        .wr        (bus_wr),
        .wdata     (bus_wdata),
        .mask      (width_mask),
        .tx_en     (tx_en),
        .shf_ready (shf_ready),
        .shf_load  (shf_load),
        .shf_data  (shf_data),
        .empty     (tx_empty)
    );

    dr_rx_fifo #(
        .DEPTH (RX_DEPTH),
        .WIDTH (DW)
    ) u_rx (
        .clk   (clk),
        .rst   (rst),
        .push  (rx_push),
        .pdata (rx_char & width_mask),
        .rd    (bus_rd),
        .head  (rx_head),
        .count (rx_count),
        .ovr   (rx_overrun)
    );

    assign rx_avail  = (rx_count != '0);
    assign bus_rdata = (bus_rd && rx_avail) ? rx_head : '0;

endmodule

// File: rtl/dr_checker.sv
`timescale 1ns/1ps
module dr_checker
    import uart_dr_pkg::*;
#(
    parameter int RX_DEPTH = 2,
    localparam int CW      = $clog2(RX_DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [7:0]    bus_rdata,
    input logic [1:0]    char_sz,
    input logic          tx_en,
    input logic          shf_ready,
    input logic          shf_load,
    input logic [7:0]    shf_data,
    input logic          rx_push,
    input logic          tx_empty,
    input logic          rx_avail,
    input logic          rx_overrun,
    input logic [CW-1:0] rx_count
);

    a_r6_load_needs_enable: assert property (@(posedge clk) disable iff (rst)
        shf_load |-> (tx_en && shf_ready));

    a_r6_empty_after_load: assert property (@(posedge clk) disable iff (rst)
        shf_load |=> tx_empty);

    a_r1_accept_clears_empty: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && tx_empty) |=> !tx_empty);

    a_r5_blocked_write: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !tx_empty && !shf_load) |=> (!tx_empty && $stable(shf_data)));

    a_r8_avail_after_push: assert property (@(posedge clk) disable iff (rst)
        rx_push |=> rx_avail);

    a_r9_overrun_on_drop: assert property (@(posedge clk) disable iff (rst)
        (rx_push && !bus_rd && rx_count == CW'(RX_DEPTH)) |=> rx_overrun);

    a_r9_read_clears_overrun: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> !rx_overrun);

    a_r10_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !rx_avail) |-> (bus_rdata == 8'h00));

    a_r4_upper_bits_zero: assert property (@(posedge clk) disable iff (rst)
        bus_rd |-> ((bus_rdata & ~csz_mask(csz_e'(char_sz))) == 8'h00));

    a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
        rx_count <= CW'(RX_DEPTH));

endmodule

bind uart_data_reg_buf dr_checker #(.RX_DEPTH(RX_DEPTH)) u_dr_checker (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .char_sz    (char_sz),
    .tx_en      (tx_en),
    .shf_ready  (shf_ready),
    .shf_load   (shf_load),
    .shf_data   (shf_data),
    .rx_push    (rx_push),
    .tx_empty   (tx_empty),
    .rx_avail   (rx_avail),
    .rx_overrun (rx_overrun),
    .rx_count   (rx_count)
);

// File: tb/test_uart_data_reg_buf.sv
`timescale 1ns/1ps
module test_uart_data_reg_buf;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] char_sz = 2'd3;
    logic       tx_en = 1'b0, shf_ready = 1'b0;
    logic       shf_load;
    logic [7:0] shf_data;
    logic       rx_push = 1'b0;
    logic [7:0] rx_char = '0;
    logic       tx_empty, rx_avail, rx_overrun;

    int vectors = 0;
    int errors  = 0;

    // reference model state
    bit         m_full = 0;
    logic [7:0] m_dat  = '0;
    logic [7:0] m_q[$];
    bit         m_ovr  = 0;

    always #5 clk = ~clk;

    uart_data_reg_buf i_uart_data_reg_buf (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .char_sz(char_sz),
        .tx_en(tx_en), .shf_ready(shf_ready), .shf_load(shf_load),
        .shf_data(shf_data), .rx_push(rx_push), .rx_char(rx_char),
        .tx_empty(tx_empty), .rx_avail(rx_avail), .rx_overrun(rx_overrun)
    );

    function automatic logic [7:0] ref_mask(input logic [1:0] sz);
        return 8'((9'd1 << (5 + int'(sz))) - 9'd1);
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, compare mid-cycle, advance the model at the rising edge.
    task automatic step(input logic wr, input logic [7:0] wd, input logic rd,
                        input logic push, input logic [7:0] rc,
                        input logic en, input logic rdy);
        bit         e_load;
        logic [7:0] e_rd;
        bus_wr = wr; bus_wdata = wd; bus_rd = rd;
        rx_push = push; rx_char = rc; tx_en = en; shf_ready = rdy;
        #2;
        e_load = m_full && en && rdy;
        e_rd   = (rd && m_q.size() != 0) ? m_q[0] : 8'h00;
        chk("R5 R6 R11 tx_empty", {7'd0, tx_empty}, {7'd0, !m_full});
        chk("R6 R11 shf_load", {7'd0, shf_load}, {7'd0, e_load});
        if (e_load) chk("R1 R3 shf_data", shf_data, m_dat);
        chk("R8 R11 rx_avail", {7'd0, rx_avail}, {7'd0, m_q.size() != 0});
        chk("R9 R11 rx_overrun", {7'd0, rx_overrun}, {7'd0, m_ovr});
        if (rd) chk("R2 R4 R7 R10 bus_rdata", bus_rdata, e_rd);
        @(posedge clk);
        if (e_load) m_full = 0;
        if (wr && !m_full && !e_load) begin
            m_full = 1;
            m_dat  = wd & ref_mask(char_sz);
        end
        if (rd) begin
            if (m_q.size() != 0) void'(m_q.pop_front());
            m_ovr = 0;
        end
        if (push) begin
            if (m_q.size() < 2) m_q.push_back(rc & ref_mask(char_sz));
            else                m_ovr = 1;
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0, 8'h00, 0, 0);
    endtask

    task automatic drain();
        for (int i = 0; i < 4; i++) step(0, 8'h00, 1, 0, 8'h00, 1, 1);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11: reset state
        idle(2);

        // R6 hold while disabled, R5 dropped write, R1 handoff at 8 bits
        char_sz = 2'd3;
        step(1, 8'hA5, 0, 0, 8'h00, 0, 0);
        step(1, 8'h3C, 0, 0, 8'h00, 0, 1);   // R5: dropped, tx disabled
        idle(3);
        step(0, 8'h00, 0, 0, 8'h00, 1, 0);   // enabled, shifter busy
        step(1, 8'h77, 0, 0, 8'h00, 1, 0);   // R5: dropped again
        step(0, 8'h00, 0, 0, 8'h00, 1, 1);   // R1: load of A5
        step(1, 8'h5A, 0, 0, 8'h00, 1, 0);   // R6: accepted right after load
        step(0, 8'h00, 0, 0, 8'h00, 1, 1);

        // R3: width masking on transmit, every width code
        for (int s = 0; s < 4; s++) begin
            char_sz = 2'(s);
            step(1, 8'hFF, 0, 0, 8'h00, 1, 0);
            step(0, 8'h00, 0, 0, 8'h00, 1, 1);
        end

        // R7 R9: fill, overrun, reads in order, R10 empty reads
        char_sz = 2'd3;
        step(0, 8'h00, 0, 1, 8'h11, 0, 0);
        step(0, 8'h00, 0, 1, 8'h22, 0, 0);
        step(0, 8'h00, 0, 1, 8'h33, 0, 0);   // R9: dropped
        idle(1);
        step(0, 8'h00, 1, 0, 8'h00, 0, 0);   // R2: 11, clears overrun
        step(0, 8'h00, 1, 0, 8'h00, 0, 0);   // 22
        step(0, 8'h00, 1, 0, 8'h00, 0, 0);   // R10: empty, zero
        step(0, 8'h00, 1, 0, 8'h00, 0, 0);
        idle(1);

        // R7: full FIFO with push and read in the same cycle keeps the push
        step(0, 8'h00, 0, 1, 8'h44, 0, 0);
        step(0, 8'h00, 0, 1, 8'h55, 0, 0);
        step(0, 8'h00, 1, 1, 8'h66, 0, 0);
        drain();

        // R4: receive masking at 6 bits
        char_sz = 2'd1;
        step(0, 8'h00, 0, 1, 8'hE7, 0, 0);
        step(0, 8'h00, 1, 0, 8'h00, 0, 0);
        drain();

        // random traffic per width; width changes only once drained
        for (int s = 0; s < 4; s++) begin
            char_sz = 2'(s);
            for (int i = 0; i < 3000; i++) begin
                step(1'($urandom % 3 == 0), 8'($urandom),
                     1'($urandom % 3 == 0),
                     1'($urandom % 2), 8'($urandom),
                     1'($urandom % 4 != 0), 1'($urandom % 2));
            end
            drain();
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule